// File: doc/BRIEF.md
# Grouped Interrupt Priority Preemption Unit

This unit decides whether a newly pending interrupt may interrupt the handler that is running now. Every interrupt carries an 8-bit priority byte, but only its three most significant bits are stored; the five low bits are always zero. A 3-bit grouping selector places a binary point inside those three bits. The bits above the point form the group priority and the bits below it form the subpriority. Only the group priority decides preemption. The subpriority orders interrupts within one group and never lets one interrupt displace another.

The unit splits the priority of the active interrupt and the priority of the candidate into their two fields, combinationally. It then registers a preempt decision. A second combinational path unpacks a 32-bit register that holds four priority bytes. It returns each byte with the unimplemented low bits forced to zero.

Top module: `irq_preempt_unit`

## Requirements
- R1: Only priority bits 7:5 take part in any field or decision; bits 4:0 of an incoming priority byte have no effect on any output.
- R2: The 32-bit unpack output holds, for slot k (k = 0..3), input bits [8k+7:8k+5] at the same positions, and zero in bits [8k+4:8k].
- R3: With grouping selector 0, 1, 2, 3 or 4, the group field equals priority bits 7:5 and the subpriority field is 0.
- R4: With grouping selector 5, the group field equals priority bits 7:6, right-justified, and the subpriority field equals bit 5.
- R5: With grouping selector 6, the group field equals priority bit 7 and the subpriority field equals bits 6:5.
- R6: With grouping selector 7, the group field is 0 and the subpriority field equals priority bits 7:5.
- R7: When both candidate and active are valid, preempt is 1 only if the candidate group value is strictly less than the active group value; equal groups give 0 whatever the subpriorities are.
- R8: A valid candidate with no valid active interrupt gives preempt 1, whatever the priorities are.
- R9: With the candidate not valid, preempt is 0.
- R10: With grouping selector 7 and a valid active interrupt, preempt is 0 for every candidate.
- R11: Preempt is registered: it reflects the inputs sampled at the previous rising edge. It is 0 after synchronous reset. The field outputs follow the inputs with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| grouping | input | 3 | Binary point selector |
| act_prio | input | 8 | Priority byte of the active interrupt |
| act_valid | input | 1 | An interrupt is active |
| cand_prio | input | 8 | Priority byte of the candidate interrupt |
| cand_valid | input | 1 | A candidate is pending |
| prio_word | input | 32 | Packed register holding four priority bytes |
| slot_prio | output | 32 | Four priority bytes with low bits zeroed |
| act_group | output | 3 | Group field of the active priority, right-justified |
| act_sub | output | 3 | Subpriority field of the active priority |
| cand_group | output | 3 | Group field of the candidate priority, right-justified |
| cand_sub | output | 3 | Subpriority field of the candidate priority |
| preempt | output | 1 | Registered preemption decision |

## Verification
A wrong binary point shows at once on the four field outputs, in the same cycle, for any priority whose three implemented bits are not all equal. A fault in the decision register shows one rising edge after the inputs change. It is most visible for equal groups with different subpriorities, for grouping selector 7, and for a candidate arriving with nothing active. A register that updates early or late shows as a preempt value that belongs to the wrong set of inputs. The bench checks preempt both before and after each edge to catch this.

// File: rtl/irqprio_pkg.sv
package irqprio_pkg;
  localparam int PRIO_W  = 8;
  localparam int IMPL_W  = 3;
  localparam int SEL_W   = 3;
  localparam int SLOTS   = 4;
  localparam int WORD_W  = PRIO_W * SLOTS;

  // number of subpriority bits for a selector value, clamped to the implemented width
  function automatic int sub_bits(input logic [SEL_W-1:0] sel, input int prio_w, input int impl_w);
    int n;
    n = int'(sel) + 1 - (prio_w - impl_w);
    if (n < 0) n = 0;
    if (n > impl_w) n = impl_w;
    return n;
  endfunction
endpackage

// File: rtl/irqprio_split.sv
module irqprio_split
  import irqprio_pkg::*;
#(
  parameter int P_W = PRIO_W,
  parameter int I_W = IMPL_W,
  parameter int S_W = SEL_W
) (
  input  logic [S_W-1:0] sel_i,
  input  logic [P_W-1:0] prio_i,
  output logic [I_W-1:0] group_o,
  output logic [I_W-1:0] sub_o
);
  logic [I_W-1:0] impl;
  int             nsub;

  assign impl = prio_i[P_W-1 -: I_W];

  always_comb begin
    nsub    = sub_bits(sel_i, P_W, I_W);
    group_o = '0;
    sub_o   = '0;
    for (int b = 0; b < I_W; b++) begin
      if (b < nsub)       sub_o[b]   = impl[b];
      if (b + nsub < I_W) group_o[b] = impl[b + nsub];
    end
  end
endmodule

// File: rtl/irqprio_unpack.sv
module irqprio_unpack
  import irqprio_pkg::*;
#(
  parameter int P_W = PRIO_W,
  parameter int I_W = IMPL_W,
  parameter int N   = SLOTS,
  localparam int W  = P_W * N
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] slot_o
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    assign slot_o[k*P_W +: P_W] = {word_i[k*P_W + P_W - 1 -: I_W], {(P_W - I_W){1'b0}}};
  end
endmodule

// File: rtl/irqprio_decide.sv
module irqprio_decide
  import irqprio_pkg::*;
#(
  parameter int I_W = IMPL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cand_valid_i,
  input  logic           act_valid_i,
  input  logic [I_W-1:0] cand_group_i,
  input  logic [I_W-1:0] act_group_i,
  output logic           preempt_o
);
  logic wins;

  assign wins = cand_valid_i && (!act_valid_i || (cand_group_i < act_group_i));

  always_ff @(posedge clk) begin
    if (rst) preempt_o <= 1'b0;
    else     preempt_o <= wins;
  end

  // R8: idle core lets any valid candidate through
  p_idle_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (cand_valid_i && !act_valid_i) |=> preempt_o);

  // R9: no candidate, no preemption
  p_no_cand_r9: assert property (@(posedge clk) disable iff (rst)
    !cand_valid_i |=> !preempt_o);

  // R7: equal groups never preempt
  p_equal_group_r7: assert property (@(posedge clk) disable iff (rst)
    (act_valid_i && cand_group_i == act_group_i) |=> !preempt_o);
endmodule

// File: rtl/irq_preempt_unit.sv
module irq_preempt_unit
  import irqprio_pkg::*;
#(
  parameter int P_W = PRIO_W,
  parameter int I_W = IMPL_W,
  parameter int S_W = SEL_W,
  parameter int N   = SLOTS,
  localparam int W  = P_W * N
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [S_W-1:0] grouping,
  input  logic [P_W-1:0] act_prio,
  input  logic           act_valid,
  input  logic [P_W-1:0] cand_prio,
  input  logic           cand_valid,
  input  logic [W-1:0]   prio_word,
  output logic [W-1:0]   slot_prio,
  output logic [I_W-1:0] act_group,
  output logic [I_W-1:0] act_sub,
  output logic [I_W-1:0] cand_group,
  output logic [I_W-1:0] cand_sub,
  output logic           preempt
);
  localparam logic [S_W-1:0] SEL_MAX = '1;

  irqprio_split #(.P_W(P_W), .I_W(I_W), .S_W(S_W)) u_split_act (
    .sel_i(grouping), .prio_i(act_prio), .group_o(act_group), .sub_o(act_sub));

  irqprio_split #(.P_W(P_W), .I_W(I_W), .S_W(S_W)) u_split_cand (
    .sel_i(grouping), .prio_i(cand_prio), .group_o(cand_group), .sub_o(cand_sub));

  irqprio_unpack #(.P_W(P_W), .I_W(I_W), .N(N)) u_unpack (
    .word_i(prio_word), .slot_o(slot_prio));

  irqprio_decide #(.I_W(I_W)) u_decide (
    .clk(clk), .rst(rst),
    .cand_valid_i(cand_valid), .act_valid_i(act_valid),
    .cand_group_i(cand_group), .act_group_i(act_group),
    .preempt_o(preempt));

  // R10: top selector leaves no group bits, so nothing preempts an active handler
  p_top_sel_r10: assert property (@(posedge clk) disable iff (rst)
    (grouping == SEL_MAX && act_valid) |=> !preempt);

  // R2: unimplemented bits of every slot read zero
  p_low_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (slot_prio & ~{N{{I_W{1'b1}}, {(P_W - I_W){1'b0}}}}) == '0);

  // R6: top selector yields a zero group field
  p_top_group_r6: assert property (@(posedge clk) disable iff (rst)
    (grouping == SEL_MAX) |-> (act_group == '0 && cand_group == '0));
endmodule

// File: tb/sim_irq_preempt_unit.sv
`timescale 1ns/1ps
module sim_irq_preempt_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  grouping;
  logic [7:0]  act_prio, cand_prio;
  logic        act_valid, cand_valid;
  logic [31:0] prio_word, slot_prio;
  logic [2:0]  act_group, act_sub, cand_group, cand_sub;
  logic        preempt;

  int checks = 0;
  int errors = 0;
  logic exp_prev;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_preempt_unit u0 (
    .clk(clk), .rst(rst), .grouping(grouping),
    .act_prio(act_prio), .act_valid(act_valid),
    .cand_prio(cand_prio), .cand_valid(cand_valid),
    .prio_word(prio_word), .slot_prio(slot_prio),
    .act_group(act_group), .act_sub(act_sub),
    .cand_group(cand_group), .cand_sub(cand_sub),
    .preempt(preempt));

  function automatic int nsub(input logic [2:0] g);
    return (g <= 3'd4) ? 0 : int'(g) - 4;
  endfunction

  function automatic logic [2:0] exp_group(input logic [7:0] p, input logic [2:0] g);
    return p[7:5] >> nsub(g);
  endfunction

  function automatic logic [2:0] exp_sub(input logic [7:0] p, input logic [2:0] g);
    logic [2:0] m;
    m = 3'((4'd1 << nsub(g)) - 4'd1);
    return p[7:5] & m;
  endfunction

  function automatic logic exp_pre(input logic [2:0] g, input logic av, input logic [7:0] ap,
                                   input logic cv, input logic [7:0] cp);
    if (!cv) return 1'b0;
    if (!av) return 1'b1;
    return exp_group(cp, g) < exp_group(ap, g);
  endfunction

  function automatic string rq(input logic [2:0] g);
    case (g)
      3'd5: return "R4";
      3'd6: return "R5";
      3'd7: return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, check fields, then the registered decision
  task automatic apply(input logic [2:0] g, input logic av, input logic [7:0] ap,
                       input logic cv, input logic [7:0] cp, input logic [31:0] w, input string req);
    logic e;
    @(negedge clk);
    grouping = g; act_valid = av; act_prio = ap; cand_valid = cv; cand_prio = cp; prio_word = w;
    #1;
    chk(rq(g), "act_group", 32'(act_group), 32'(exp_group(ap, g)));
    chk(rq(g), "act_sub", 32'(act_sub), 32'(exp_sub(ap, g)));
    chk(rq(g), "cand_group", 32'(cand_group), 32'(exp_group(cp, g)));
    chk(rq(g), "cand_sub", 32'(cand_sub), 32'(exp_sub(cp, g)));
    chk("R2", "slot_prio", slot_prio, w & 32'hE0E0_E0E0);
    chk("R11", "preempt held before edge", 32'(preempt), 32'(exp_prev));
    e = exp_pre(g, av, ap, cv, cp);
    @(posedge clk); #1;
    chk(req, "preempt", 32'(preempt), 32'(e));
    exp_prev = e;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = 32'd1234;
    void'($urandom(seed));
    rst = 1'b1; grouping = 3'd0; act_prio = 8'h0; cand_prio = 8'h0;
    act_valid = 1'b0; cand_valid = 1'b1; prio_word = 32'h0;
    repeat (3) @(posedge clk);
    #1;
    chk("R11", "preempt in reset", 32'(preempt), 32'd0);
    @(negedge clk);
    rst = 1'b0; cand_valid = 1'b0;
    exp_prev = 1'b0;

    // R1: low bits ignored, equal groups never preempt
    apply(3'd2, 1'b1, 8'h60, 1'b1, 8'h7F, 32'hFFFF_FFFF, "R1");
    // R7: equal group, candidate better subpriority
    apply(3'd5, 1'b1, 8'hA0, 1'b1, 8'h80, 32'h1234_5678, "R7");
    // R7: strictly lower group preempts
    apply(3'd5, 1'b1, 8'hA0, 1'b1, 8'h40, 32'hE0E0_E0E0, "R7");
    // R7: higher group does not
    apply(3'd6, 1'b1, 8'h60, 1'b1, 8'h80, 32'h1F1F_1F1F, "R7");
    // R10: top selector, best candidate against worst active
    apply(3'd7, 1'b1, 8'hE0, 1'b1, 8'h00, 32'hA5A5_A5A5, "R10");
    // R8: nothing active
    apply(3'd7, 1'b0, 8'h00, 1'b1, 8'hE0, 32'h0000_0000, "R8");
    apply(3'd0, 1'b0, 8'h00, 1'b1, 8'hFF, 32'h8040_2010, "R8");
    // R9: no candidate
    apply(3'd0, 1'b1, 8'hE0, 1'b0, 8'h00, 32'hC0C0_C0C0, "R9");
    apply(3'd4, 1'b0, 8'hE0, 1'b0, 8'h00, 32'h0101_0101, "R9");

    for (int i = 0; i < 400; i++) begin
      logic [2:0] g;
      g = 3'($urandom);
      apply(g, 1'($urandom), 8'($urandom), 1'($urandom_range(0, 3) != 0), 8'($urandom), $urandom, "R7");
    end

    // R11: reset clears a pending 1
    apply(3'd0, 1'b0, 8'h00, 1'b1, 8'h00, 32'h0, "R8");
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R11", "preempt after reset", 32'(preempt), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule